// File: doc/BRIEF.md
# USB Transmit Bit Serializer

This block turns a stream of parallel bytes from a link-layer controller into the serial symbol stream that a USB line driver puts on the wire. The controller raises `tx_valid` with a byte on `tx_data`; the block answers with a `tx_ready` pulse each time it takes a byte. It opens every packet with a synchronisation pattern, shifts each byte out least significant bit first, inserts a zero after every run of six ones, and NRZI-encodes the result. When the controller lowers `tx_valid` at a byte boundary, the block sends an end-of-packet sequence and then releases the line.

The line runs at a rate set by `bit_en`, a strobe that is high for one clock per bit time. Each strobe advances the line by one symbol. The symbol is a J, K or SE0 code that comes with an output enable. A two-bit mode input picks normal operation, a raw mode that skips both stuffing and NRZI, or a non-driving mode in which the block ignores transmit requests. For a few clocks after reset the block also refuses to start a packet.

Top module: `usb_tx_serializer`

## Requirements
- R1: While `rst_n` is low, `line_oe` is 0, `line_sym` is J (2'b01) and `tx_ready` is 0.
- R2: A packet cannot start until five rising clock edges have passed since reset was released. If `bit_en` is high every clock and `tx_valid` is held high from the release, `line_oe` is still 0 after the sixth edge and is 1 after the seventh edge.
- R3: In normal mode (`op_mode` 2'b00), an accepted `tx_valid` starts the packet on the next `bit_en`. The first eight symbols are K J K J K J K K, which is seven zeros and then a one, NRZI-encoded from an idle J.
- R4: `tx_ready` is high for one clock only. It is high only while `tx_valid` is high, and only in a `bit_en` cycle that sends the last bit of the sync pattern or of the previous byte. In that cycle `tx_data` is captured, and its bits are then sent least significant bit first.
- R5: In normal mode, a zero is inserted after every six consecutive one bits. This also happens when the sixth one is the last data bit before end-of-packet.
- R6: In normal mode, a zero bit toggles the line between J and K and a one bit holds it. The line never shows the code 2'b11.
- R7: If `tx_valid` is low when the last bit of the sync pattern or of a byte is sent, the next three symbols are SE0 (2'b00), SE0, J. One bit time later `line_oe` falls with the line at J.
- R8: In raw mode (`op_mode` 2'b10), no zero is inserted and each bit maps directly to a symbol: 1 gives J and 0 gives K. Sync and end-of-packet are sent as in normal mode.
- R9: In mode 2'b01 and in mode 2'b11, `tx_valid` is ignored: `line_oe` stays 0 and `tx_ready` stays 0.
- R10: `line_sym` and `line_oe` change only on the clock edge that follows a cycle with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low. It may assert asynchronously but must be released synchronously |
| bit_en | input | 1 | Bit-time strobe; one line symbol per high cycle |
| op_mode | input | 2 | 00 normal, 01 non-driving, 10 raw (no stuffing or NRZI), 11 treated as non-driving |
| tx_valid | input | 1 | Controller has a byte to send; its rise opens a packet, its fall ends it |
| tx_data | input | BYTE_W | Byte to send, held stable until `tx_ready` |
| tx_ready | output | 1 | Byte on `tx_data` captured this clock |
| line_sym | output | 2 | Line symbol: 00 SE0, 01 J, 10 K |
| line_oe | output | 1 | Line driver enable |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a stuffing run of six and a five-edge lockout. These values give the sync pattern and the stuffing of a real full-speed line, so the bench can predict every symbol from its own model. It can also place a six-ones run across a byte boundary and right before end-of-packet. The bench runs `bit_en` at one, two and three clocks per bit. Running it every clock lets the bench find the exact edge where the lockout ends. The slower rates show that the line holds steady between strobes.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10
  } line_sym_e;

  typedef enum logic [1:0] {
    EM_BIT,
    EM_SE0,
    EM_J,
    EM_OFF
  } emit_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_SE0A,
    ST_SE0B,
    ST_JEND,
    ST_DONE
  } tx_state_e;

endpackage

// File: rtl/usb_tx_lockout.sv
module usb_tx_lockout #(
  parameter int unsigned LOCKOUT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  localparam int unsigned CW = $clog2(LOCKOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCKOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  assign armed = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!armed) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usb_tx_stuffer.sv
module usb_tx_stuffer #(
  parameter int unsigned RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_val,
  input  logic stuff_en,
  output logic need_stuff
);
  localparam int unsigned OW = $clog2(RUN_LEN + 1);
  localparam logic [OW-1:0] RUN = OW'(RUN_LEN);

  logic [OW-1:0] ones_q, ones_d;

  assign need_stuff = stuff_en && (ones_q == RUN);

  always_comb begin
    ones_d = ones_q;
    if (clr)                    ones_d = '0;
    else if (step && !bit_val)  ones_d = '0;
    else if (step && ones_q != RUN) ones_d = ones_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end
endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
  import usb_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        emit,
  input  emit_e       kind,
  input  logic        bit_val,
  input  logic        nrzi_en,
  output line_sym_e   sym,
  output logic        oe
);
  line_sym_e sym_d;
  logic      oe_d;

  always_comb begin
    sym_d = sym;
    oe_d  = oe;
    if (emit) begin
      unique case (kind)
        EM_BIT: begin
          oe_d = 1'b1;
          if (!nrzi_en)     sym_d = bit_val ? SYM_J : SYM_K;
          else if (!bit_val) sym_d = (sym == SYM_K) ? SYM_J : SYM_K;
        end
        EM_SE0: begin oe_d = 1'b1; sym_d = SYM_SE0; end
        EM_J:   begin oe_d = 1'b1; sym_d = SYM_J;   end
        default: begin oe_d = 1'b0; sym_d = SYM_J;  end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym <= SYM_J;
      oe  <= 1'b0;
    end else begin
      sym <= sym_d;
      oe  <= oe_d;
    end
  end
endmodule

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              armed,
  input  logic              drive_ok,
  input  logic              need_stuff,
  output logic              tx_ready,
  output logic              emit,
  output emit_e             kind,
  output logic              emit_bit,
  output logic              idle
);
  localparam int unsigned CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] SYNC_PAT = {1'b1, {(BYTE_W-1){1'b0}}};

  tx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign idle = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    emit     = 1'b0;
    kind     = EM_BIT;
    emit_bit = 1'b0;
    tx_ready = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_valid && armed && drive_ok) begin
          sh_d    = SYNC_PAT;
          cnt_d   = '0;
          state_d = ST_SYNC;
        end
      end
      ST_SYNC, ST_DATA: begin
        if (bit_en) begin
          emit = 1'b1;
          if (!need_stuff) begin
            emit_bit = sh_q[0];
            if (cnt_q == LAST) begin
              if (tx_valid) begin
                tx_ready = 1'b1;
                sh_d     = tx_data;
                cnt_d    = '0;
                state_d  = ST_DATA;
              end else begin
                state_d  = ST_SE0A;
              end
            end else begin
              sh_d  = sh_q >> 1;
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
      end
      ST_SE0A: begin
        if (bit_en) begin
          emit = 1'b1;
          if (!need_stuff) begin
            kind    = EM_SE0;
            state_d = ST_SE0B;
          end
        end
      end
      ST_SE0B: if (bit_en) begin emit = 1'b1; kind = EM_SE0; state_d = ST_JEND; end
      ST_JEND: if (bit_en) begin emit = 1'b1; kind = EM_J;   state_d = ST_DONE; end
      default: if (bit_en) begin emit = 1'b1; kind = EM_OFF; state_d = ST_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usb_tx_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned STUFF_RUN   = 6,
  parameter int unsigned LOCKOUT_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        op_mode,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic [1:0]        line_sym,
  output logic              line_oe
);
  logic      armed, need_stuff, emit, emit_bit, idle;
  logic      drive_ok, coded;
  emit_e     kind;
  line_sym_e sym;

  assign drive_ok = !op_mode[0];
  assign coded    = (op_mode == 2'b00);
  assign line_sym = sym;

  usb_tx_lockout #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_lockout (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed)
  );

  usb_tx_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .armed      (armed),
    .drive_ok   (drive_ok),
    .need_stuff (need_stuff),
    .tx_ready   (tx_ready),
    .emit       (emit),
    .kind       (kind),
    .emit_bit   (emit_bit),
    .idle       (idle)
  );

  usb_tx_stuffer #(.RUN_LEN(STUFF_RUN)) u_stuffer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (idle),
    .step       (emit && (kind == EM_BIT)),
    .bit_val    (emit_bit),
    .stuff_en   (coded),
    .need_stuff (need_stuff)
  );

  usb_tx_line u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .emit    (emit),
    .kind    (kind),
    .bit_val (emit_bit),
    .nrzi_en (coded),
    .sym     (sym),
    .oe      (line_oe)
  );
endmodule

// File: rtl/usb_tx_serializer_chk.sv
module usb_tx_serializer_chk #(
  parameter int unsigned LOCKOUT_CYC = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [1:0] op_mode,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] line_sym,
  input logic       line_oe
);
  localparam int unsigned SW = $clog2(LOCKOUT_CYC + 2) + 1;
  localparam logic [SW-1:0] SAT = SW'(LOCKOUT_CYC + 1);

  logic [SW-1:0] seen_q;
  logic          nodrive;

  assign nodrive = (op_mode == 2'b01) || (op_mode == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_q <= '0;
    else if (seen_q != SAT) seen_q <= seen_q + 1'b1;
  end

  p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q < SAT) |-> !line_oe);

  p_ready_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid);

  p_ready_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bit_en);

  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  p_no_se1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_sym != 2'b11);

  p_release_at_j_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> (line_sym == 2'b01));

  p_nodrive_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nodrive && !line_oe) |=> !line_oe);

  p_nodrive_noack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nodrive |-> !tx_ready);

  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(line_sym) && $stable(line_oe)));
endmodule

bind usb_tx_serializer usb_tx_serializer_chk #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .op_mode  (op_mode),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .line_sym (line_sym),
  .line_oe  (line_oe)
);

// File: tb/usb_tx_serializer_bench.sv
module usb_tx_serializer_bench;
  localparam logic [1:0] S_SE0 = 2'b00;
  localparam logic [1:0] S_J   = 2'b01;
  localparam logic [1:0] S_K   = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic [1:0] op_mode;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready;
  logic [1:0] line_sym;
  logic       line_oe;

  int total = 0;
  int bad   = 0;
  int bit_div = 1;
  int div_cnt = 0;
  logic bit_en_q = 1'b0;
  logic oe_prev = 1'b0;
  logic [2:0] prev_line = 3'b001;
  logic [7:0] pkt[$];
  logic [2:0] exp_q[$];
  bit done = 0;

  usb_tx_serializer u_usb_tx_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .op_mode(op_mode),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .line_sym(line_sym), .line_oe(line_oe)
  );

  always #4 clk = ~clk;

  // bit-time strobe generator
  always @(posedge clk) begin
    #1;
    if (div_cnt >= bit_div - 1) begin div_cnt = 0; bit_en = 1'b1; end
    else begin div_cnt++; bit_en = 1'b0; end
  end

  always @(posedge clk) bit_en_q <= bit_en;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop per bit time, hold check between strobes
  always @(negedge clk) begin
    if (rst_n) begin
      if (!bit_en_q) begin
        check({line_oe, line_sym} == prev_line, "R10 line moved without strobe",
              {line_oe, line_sym}, prev_line);
      end else if (line_oe || oe_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 R7 unexpected symbol", {line_oe, line_sym}, 0);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check({line_oe, line_sym} == e, "R3,R5,R6,R7,R8 line symbol",
                {line_oe, line_sym}, e);
        end
      end
    end
    oe_prev   = line_oe;
    prev_line = {line_oe, line_sym};
  end

  function automatic void put_bit(input bit b, input bit raw, inout logic [1:0] lvl);
    if (raw) exp_q.push_back({1'b1, b ? S_J : S_K});
    else begin
      if (!b) lvl = (lvl == S_K) ? S_J : S_K;
      exp_q.push_back({1'b1, lvl});
    end
  endfunction

  // independent model of the expected line stream
  function automatic void build_expect(input logic [1:0] mode);
    bit bq[$];
    logic [1:0] lvl;
    int ones;
    bit raw;
    raw  = (mode == 2'b10);
    lvl  = S_J;
    ones = 0;
    for (int i = 0; i < 7; i++) bq.push_back(1'b0);
    bq.push_back(1'b1);
    foreach (pkt[i]) for (int b = 0; b < 8; b++) bq.push_back(pkt[i][b]);
    foreach (bq[k]) begin
      put_bit(bq[k], raw, lvl);
      if (!raw) begin
        ones = bq[k] ? ones + 1 : 0;
        if (ones == 6) begin put_bit(1'b0, raw, lvl); ones = 0; end
      end
    end
    exp_q.push_back({1'b1, S_SE0});
    exp_q.push_back({1'b1, S_SE0});
    exp_q.push_back({1'b1, S_J});
    exp_q.push_back({1'b0, S_J});
  endfunction

  task automatic drive_pkt(input int n);
    int rdy = 0;
    tx_valid = 1'b1;
    if (n == 0) begin
      do @(negedge clk); while (!line_oe);
      @(posedge clk); #1;
      tx_valid = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      tx_data = pkt[i];
      do @(negedge clk); while (!tx_ready);
      rdy++;
      @(posedge clk); #1;
    end
    tx_valid = 1'b0;
    do @(negedge clk); while (line_oe);
    check(rdy == n, "R4 ready pulse count", rdy, n);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] mode, input int div);
    bit_div = div;
    op_mode = mode;
    build_expect(mode);
    drive_pkt(pkt.size());
    check(exp_q.size() == 0, "R7 stream complete", exp_q.size(), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; op_mode = 2'b00; tx_valid = 1'b0; tx_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(line_oe == 1'b0, "R1 oe in reset", line_oe, 0);
    check(line_sym == S_J, "R1 sym in reset", line_sym, S_J);
    check(tx_ready == 1'b0, "R1 ready in reset", tx_ready, 0);

    // R2 lockout: tx_valid high from release, strobe every clock
    bit_div = 1;
    pkt = '{8'hA5};
    build_expect(2'b00);
    tx_valid = 1'b1; tx_data = 8'hA5;
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(line_oe == 1'b0, "R2 still locked after sixth edge", line_oe, 0);
    @(posedge clk); @(negedge clk);
    check(line_oe == 1'b1, "R2 started after seventh edge", line_oe, 1);
    drive_pkt(1);

    // R3 R6 plain zero byte, strobe every clock
    pkt = '{8'h00};
    send(2'b00, 1);
    // R5 stuffing across byte boundary, slow strobe
    pkt = '{8'hFF, 8'hFF, 8'h3F, 8'h81};
    send(2'b00, 3);
    // R5 six ones right before end-of-packet
    pkt = '{8'hFC};
    send(2'b00, 2);
    // R7 tx_valid dropped during sync: sync then end-of-packet
    pkt = {};
    send(2'b00, 2);
    // R8 raw mode, no stuffing
    pkt = '{8'hFF, 8'h00, 8'h7E};
    send(2'b10, 2);

    // R9 non-driving modes ignore tx_valid
    for (int m = 1; m < 4; m += 2) begin
      op_mode = m[1:0];
      tx_valid = 1'b1; tx_data = 8'h55; bit_div = 1;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        check(line_oe == 1'b0, "R9 oe stays low", line_oe, 0);
        check(tx_ready == 1'b0, "R9 no ready", tx_ready, 0);
      end
      @(posedge clk); #1;
      tx_valid = 1'b0;
      repeat (2) @(posedge clk); #1;
    end

    // back to normal after non-driving, mixed data
    pkt = '{8'hC3, 8'h7F, 8'hFE};
    send(2'b00, 1);

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule